// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Software Force

This block collects interrupt events for a processor with fifteen interrupt levels (1 to 15, level 0 meaning "no request"). Five internal hardware sources feed it: a real-time clock tick, a general-purpose timer tick, a receive/transmit event from each of two UARTs, and a UART overflow line. A one-cycle pulse on any of them latches a pending bit at that source's level. Software reaches four registers over a small word-addressed write bus with a combinational read port. It can read the pending bits, mask levels, clear pending bits by writing ones, and force any level for test even when no hardware source drives it.

The block combines pending and forced bits, removes masked levels, and presents the index of the highest remaining level as a 4-bit request. When the processor takes an interrupt it pulses an acknowledge with the level it is servicing. That clears the forced bit of the level if one is set, and otherwise clears the pending bit.

Register selection by `reg_addr`: 0 selects pending (read-only), 1 selects mask (read-write), 2 selects clear (write-only, reads as zero) and 3 selects force (read-write). In every register, bit n stands for level n, and bit 0 always reads 0.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, pending reads 0x0000, force reads 0x0000, mask reads 0xFFFE and `irq_level` is 0.
- R2: A pulse on `uart_a_evt` sets pending bit 4, on `uart_b_evt` bit 5, on `uart_ovf` bit 1, on `gpt_tick` bit 12 and on `rtc_tick` bit 13. The bit is visible from the clock edge that samples the pulse.
- R3: Writing the clear register (address 2) clears every pending bit written as 1 and leaves the bits written as 0 unchanged. If a source pulse arrives in the same cycle as a clear of its bit, the bit stays set.
- R4: A write to the pending register (address 0) does not change the pending bits.
- R5: The force register (address 3) reads back what was written, with bit 0 reading 0. A forced level makes a request without any hardware source.
- R6: The active set is (pending OR force) AND NOT mask. A masked level makes no request, but its pending and force bits are kept.
- R7: `irq_level` is the highest active level, with 15 the highest priority and 1 the lowest. It is 0 when no level is active.
- R8: An acknowledge of level L clears force bit L if that bit is set; otherwise it clears pending bit L. A pending bit that coexists with a forced bit of the same level therefore stays set after the first acknowledge.
- R9: The clear register reads as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 pending, 1 mask, 2 clear, 3 force) |
| reg_wdata | input | 16 | Write data, bit n = level n |
| reg_rdata | output | 16 | Read data of the selected register |
| rtc_tick | input | 1 | Real-time clock event pulse (level 13) |
| gpt_tick | input | 1 | General-purpose timer event pulse (level 12) |
| uart_a_evt | input | 1 | UART A character event pulse (level 4) |
| uart_b_evt | input | 1 | UART B character event pulse (level 5) |
| uart_ovf | input | 1 | UART overflow error pulse (level 1) |
| irq_ack | input | 1 | Acknowledge strobe from the processor |
| irq_ack_lvl | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest active level, 0 when none |

## Verification
Two collisions are the hardest to produce from the ports. The first is a source pulse landing in the very cycle that a clear write names its bit. The second is one level held by a forced bit and a pending bit at once when it is acknowledged. The directed tasks reach the first by raising the UART B event and the clear write inside the same clock period. They reach the second by forcing level 5 and pulsing UART B before the acknowledge. Two acknowledges then follow, with the request level read after each.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    typedef enum logic [1:0] {
        SEL_PEND  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_CLR   = 2'd2,
        SEL_FORCE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map #(
    parameter int LVL_W = 4,
    parameter int NSRC  = 5,
    parameter logic [NSRC*LVL_W-1:0] SRC_LVL = '0,
    localparam int NL = 1 << LVL_W
) (
    input  logic [NSRC-1:0] src_pulse,
    output logic [NL-1:0]   set_vec
);
    // one OR tree per level, built from the per-source level map
    for (genvar l = 0; l < NL; l++) begin : g_lvl
        always_comb begin
            set_vec[l] = 1'b0;
            for (int s = 0; s < NSRC; s++) begin
                if (l != 0 && SRC_LVL[s*LVL_W +: LVL_W] == LVL_W'(l))
                    set_vec[l] = set_vec[l] | src_pulse[s];
            end
        end
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_ctrl_pkg::*;
#(
    parameter int LVL_W = 4,
    localparam int NL = 1 << LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wen,
    input  logic [1:0]       reg_addr,
    input  logic [NL-1:0]    reg_wdata,
    output logic [NL-1:0]    reg_rdata,
    input  logic [NL-1:0]    set_vec,
    input  logic             ack,
    input  logic [LVL_W-1:0] ack_lvl,
    output logic [NL-1:0]    pend_q,
    output logic [NL-1:0]    mask_q,
    output logic [NL-1:0]    force_q
);
    localparam logic [NL-1:0] LVL_BITS = {{(NL-1){1'b1}}, 1'b0};

    reg_sel_e        sel;
    logic            wr_pend, wr_mask, wr_clr, wr_force;
    logic [NL-1:0]   clr_vec, ack_oh, ack_force, ack_pend;
    logic [NL-1:0]   pend_d, mask_d, force_d;

    always_comb begin
        sel       = reg_sel_e'(reg_addr);
        wr_pend   = reg_wen && (sel == SEL_PEND);
        wr_mask   = reg_wen && (sel == SEL_MASK);
        wr_clr    = reg_wen && (sel == SEL_CLR);
        wr_force  = reg_wen && (sel == SEL_FORCE);
        clr_vec   = wr_clr ? reg_wdata : '0;
        ack_oh    = ack ? (NL'(1) << ack_lvl) : '0;
        ack_force = ack_oh & force_q;
        ack_pend  = ack_oh & ~force_q;
        // a new event beats any clear arriving with it
        pend_d    = ((pend_q & ~clr_vec & ~ack_pend) | set_vec) & LVL_BITS;
        mask_d    = wr_mask  ? (reg_wdata & LVL_BITS) : mask_q;
        force_d   = wr_force ? (reg_wdata & LVL_BITS) : (force_q & ~ack_force);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            mask_q  <= LVL_BITS;
            force_q <= '0;
        end else begin
            pend_q  <= pend_d;
            mask_q  <= mask_d;
            force_q <= force_d;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_PEND:  reg_rdata = pend_q;
            SEL_MASK:  reg_rdata = mask_q;
            SEL_CLR:   reg_rdata = '0;
            SEL_FORCE: reg_rdata = force_q;
            default:   reg_rdata = '0;
        endcase
    end

    // R2
    src_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    // R3
    clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !ack) |=> ((pend_q & $past(clr_vec) & ~$past(set_vec)) == '0));

    // R4
    pend_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && set_vec == '0 && !ack) |=> (pend_q == $past(pend_q)));

    // R8
    ack_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr_force && (force_q & ack_oh) != '0)
            |=> ((force_q & $past(ack_oh)) == '0 && (pend_q & $past(pend_q) & $past(ack_oh)) == ($past(pend_q) & $past(ack_oh))));

    // R5
    no_level0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0] && !force_q[0]);
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int LVL_W = 4,
    localparam int NL = 1 << LVL_W
) (
    input  logic [NL-1:0]    active,
    output logic [LVL_W-1:0] level
);
    // later iterations overwrite earlier ones: the highest index wins
    always_comb begin
        level = '0;
        for (int i = 1; i < NL; i++) begin
            if (active[i]) level = LVL_W'(i);
        end
    end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
    parameter int LVL_W    = 4,
    parameter int LVL_RTC  = 13,
    parameter int LVL_GPT  = 12,
    parameter int LVL_UA   = 4,
    parameter int LVL_UB   = 5,
    parameter int LVL_UERR = 1,
    localparam int NL   = 1 << LVL_W,
    localparam int NSRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wen,
    input  logic [1:0]       reg_addr,
    input  logic [NL-1:0]    reg_wdata,
    output logic [NL-1:0]    reg_rdata,
    input  logic             rtc_tick,
    input  logic             gpt_tick,
    input  logic             uart_a_evt,
    input  logic             uart_b_evt,
    input  logic             uart_ovf,
    input  logic             irq_ack,
    input  logic [LVL_W-1:0] irq_ack_lvl,
    output logic [LVL_W-1:0] irq_level
);
    localparam logic [NSRC*LVL_W-1:0] SRC_LVL = {
        LVL_W'(LVL_RTC), LVL_W'(LVL_GPT), LVL_W'(LVL_UERR),
        LVL_W'(LVL_UB), LVL_W'(LVL_UA)};

    logic [NSRC-1:0] src_pulse;
    logic [NL-1:0]   set_vec, pend_q, mask_q, force_q, active;

    assign src_pulse = {rtc_tick, gpt_tick, uart_ovf, uart_b_evt, uart_a_evt};

    irq_src_map #(.LVL_W(LVL_W), .NSRC(NSRC), .SRC_LVL(SRC_LVL)) u_map (
        .src_pulse (src_pulse),
        .set_vec   (set_vec)
    );

    irq_regs #(.LVL_W(LVL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .set_vec   (set_vec),
        .ack       (irq_ack),
        .ack_lvl   (irq_ack_lvl),
        .pend_q    (pend_q),
        .mask_q    (mask_q),
        .force_q   (force_q)
    );

    assign active = (pend_q | force_q) & ~mask_q;

    irq_prio #(.LVL_W(LVL_W)) u_prio (
        .active (active),
        .level  (irq_level)
    );

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (!mask_q[irq_level] && (pend_q[irq_level] || force_q[irq_level])));

    // R7
    highest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> ((active >> irq_level) == NL'(1)));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q | force_q) & ~mask_q) == '0 |-> irq_level == '0);
endmodule

// File: tb/sim_irq_ctrl_top.sv
`timescale 1ns/1ps
module sim_irq_ctrl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rtc_tick = 1'b0, gpt_tick = 1'b0, uart_a_evt = 1'b0;
    logic        uart_b_evt = 1'b0, uart_ovf = 1'b0;
    logic        irq_ack = 1'b0;
    logic [3:0]  irq_ack_lvl = '0;
    logic [3:0]  irq_level;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    irq_ctrl_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rtc_tick(rtc_tick),
        .gpt_tick(gpt_tick), .uart_a_evt(uart_a_evt), .uart_b_evt(uart_b_evt),
        .uart_ovf(uart_ovf), .irq_ack(irq_ack), .irq_ack_lvl(irq_ack_lvl),
        .irq_level(irq_level)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    // 0 uart_a, 1 uart_b, 2 uart_ovf, 3 gpt, 4 rtc
    task automatic pulse(input int s);
        @(negedge clk);
        case (s)
            0: uart_a_evt = 1'b1;
            1: uart_b_evt = 1'b1;
            2: uart_ovf   = 1'b1;
            3: gpt_tick   = 1'b1;
            default: rtc_tick = 1'b1;
        endcase
        @(negedge clk);
        {uart_a_evt, uart_b_evt, uart_ovf, gpt_tick, rtc_tick} = '0;
    endtask

    task automatic ack(input logic [3:0] l);
        @(negedge clk);
        irq_ack = 1'b1; irq_ack_lvl = l;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic lvl_is(input string tag, input logic [3:0] e);
        chk(tag, {12'd0, irq_level}, {12'd0, e});
    endtask

    task automatic t_reset;
        logic [15:0] v;
        lvl_is("R1 level after reset", 4'd0);
        rd(2'd0, v); chk("R1 pending after reset", v, 16'h0000);
        rd(2'd1, v); chk("R1 mask after reset", v, 16'hFFFE);
        rd(2'd3, v); chk("R1 force after reset", v, 16'h0000);
        rd(2'd2, v); chk("R9 clear reads zero", v, 16'h0000);
    endtask

    task automatic t_sources;
        logic [15:0] v;
        pulse(0);
        lvl_is("R6 masked source gives no request", 4'd0);
        rd(2'd0, v); chk("R2 uart_a latched while masked", v, 16'h0010);
        wr(2'd1, 16'h0000);
        lvl_is("R7 uart_a level 4", 4'd4);
        pulse(1);
        rd(2'd0, v); chk("R2 uart_b bit 5", v, 16'h0030);
        lvl_is("R7 uart_b outranks uart_a", 4'd5);
        pulse(4);
        lvl_is("R2 rtc level 13", 4'd13);
        pulse(3);
        rd(2'd0, v); chk("R2 gpt bit 12", v, 16'h3030);
        wr(2'd2, 16'hFFFF);
        rd(2'd0, v); chk("R3 clear all", v, 16'h0000);
        lvl_is("R7 idle level zero", 4'd0);
        pulse(2);
        rd(2'd0, v); chk("R2 overflow bit 1", v, 16'h0002);
        lvl_is("R7 lowest level 1", 4'd1);
        wr(2'd2, 16'h0002);
    endtask

    task automatic t_clear;
        logic [15:0] v;
        pulse(0); pulse(1);
        wr(2'd2, 16'h0010);
        rd(2'd0, v); chk("R3 selective clear", v, 16'h0020);
        wr(2'd2, 16'h0000);
        rd(2'd0, v); chk("R3 zero clear no effect", v, 16'h0020);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0030; uart_b_evt = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0; uart_b_evt = 1'b0;
        rd(2'd0, v); chk("R3 set wins over clear", v, 16'h0020);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); chk("R4 pending write ignored", v, 16'h0020);
        wr(2'd0, 16'h0000);
        rd(2'd0, v); chk("R4 pending zero write ignored", v, 16'h0020);
        wr(2'd2, 16'hFFFF);
    endtask

    task automatic t_force_mask;
        logic [15:0] v;
        wr(2'd3, 16'h8001);
        rd(2'd3, v); chk("R5 force readback bit0 zero", v, 16'h8000);
        lvl_is("R5 forced level 15", 4'd15);
        wr(2'd1, 16'h8000);
        lvl_is("R6 masked force silent", 4'd0);
        rd(2'd3, v); chk("R6 force kept while masked", v, 16'h8000);
        pulse(3);
        lvl_is("R6 unmasked gpt visible", 4'd12);
        wr(2'd1, 16'hFFFE);
        lvl_is("R6 all masked", 4'd0);
        rd(2'd0, v); chk("R6 pending kept while masked", v, 16'h1000);
        wr(2'd1, 16'h0000);
        lvl_is("R7 force 15 beats pending 12", 4'd15);
    endtask

    task automatic t_ack;
        logic [15:0] v;
        ack(4'd15);
        rd(2'd3, v); chk("R8 ack clears force bit", v, 16'h0000);
        lvl_is("R8 next level after ack", 4'd12);
        ack(4'd12);
        rd(2'd0, v); chk("R8 ack clears pending bit", v, 16'h0000);
        lvl_is("R8 idle after acks", 4'd0);
        wr(2'd3, 16'h0020);
        pulse(1);
        ack(4'd5);
        rd(2'd3, v); chk("R8 shared level force cleared", v, 16'h0000);
        rd(2'd0, v); chk("R8 shared level pending kept", v, 16'h0020);
        lvl_is("R8 still requesting 5", 4'd5);
        ack(4'd5);
        rd(2'd0, v); chk("R8 second ack clears pending", v, 16'h0000);
        lvl_is("R8 idle after second ack", 4'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sources();
        t_clear();
        t_force_mask();
        t_ack();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule